// File: doc/BRIEF.md
# Virtual Interrupt List-Register Controller

This block holds a small bank of list registers for a virtualized CPU interrupt interface, together with the control and maintenance logic around them. A hypervisor-side port writes list-register entries and a control word. It reads back any entry and the control word. A guest-side port issues acknowledge, end-of-interrupt (EOI) and deactivate operations, each carrying an interrupt ID.

Each entry moves through its state encoding in response to guest operations. Acknowledge always picks the pending entry of best priority. An entry can be linked to a physical interrupt. When the guest finishes such an entry, the block sends a one-cycle deactivation strobe with the physical ID towards the physical distributor. Deactivations whose ID matches no valid entry are counted. That count, and the number of pending entries, drive a maintenance interrupt through per-condition status bits.

Entry layout: bit 31 is the hardware-link flag. Bits [29:28] hold the state. Bits [27:23] hold the priority, where a lower value is more urgent. Bits [19:10] hold the physical ID and bits [9:0] the virtual ID. Control word layout: bit 0 is the global enable, bit 1 the underflow enable, bit 2 the not-present enable, and bits [31:27] the unmatched-deactivate count. Guest operation codes are 0 for none, 1 for acknowledge, 2 for EOI and 3 for deactivate.

Top module: `virq_lr_ctrl`

## Requirements
- R1: After reset every entry and the control word read as zero, `ack_id_o` is 1023, and `misr_o`, `maint_irq_o` and `phys_deact_o` are 0.
- R2: While enabled, `ack_id_o` is the virtual ID of the entry in state 01 (pending) with the numerically lowest priority field. A tie goes to the lowest entry index.
- R3: An acknowledge (op 1) moves the selected entry from 01 to 10 (active).
- R4: With control bit 0 clear, `ack_id_o` is 1023 and an acknowledge changes no entry.
- R5: An EOI (op 2) with `gst_eoimode_i`=0 on a matching active entry that has bit 31 set moves that entry to 00 (invalid). In the next cycle it drives `phys_deact_o` high for exactly one cycle, with `phys_id_o` equal to the entry's bits [19:10].
- R6: The same EOI on an entry with bit 31 clear moves it to 00 and raises no strobe.
- R7: A deactivation whose ID matches no entry in a state other than 00 increments the count in control bits [31:27], saturating at its maximum. A matching deactivation leaves the count unchanged.
- R8: `misr_o[0]` is 1 exactly when control bit 2 is set and the count is nonzero. `misr_o` is 0 when neither enable bit 1 nor enable bit 2 is set.
- R9: `misr_o[1]` is 1 exactly when control bit 1 is set and at most one entry has its pending state bit (bit 28) set. An acknowledge can therefore raise it.
- R10: With `gst_eoimode_i`=1, an EOI changes no entry and raises no strobe. A later deactivate (op 3) performs the state change and any physical strobe.
- R11: A hypervisor entry write takes precedence over a same-cycle guest operation on that entry. It also suppresses that operation's physical strobe.
- R12: `maint_irq_o` is 1 exactly when control bit 0 is set and some `misr_o` bit is 1.
- R13: A deactivation of an entry in state 11 (pending and active) leaves it in state 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hv_lr_we_i | input | 1 | Hypervisor entry write strobe |
| hv_lr_idx_i | input | IDX_W | Entry written |
| hv_ctrl_we_i | input | 1 | Hypervisor control-word write strobe |
| hv_wdata_i | input | 32 | Write data for entry or control word |
| hv_rd_idx_i | input | IDX_W | Entry read back |
| hv_lr_rdata_o | output | 32 | Read-back entry |
| hv_ctrl_o | output | 32 | Control word with count |
| misr_o | output | 2 | Maintenance status: [0] not-present, [1] underflow |
| maint_irq_o | output | 1 | Maintenance interrupt |
| gst_op_i | input | 2 | Guest operation code |
| gst_id_i | input | 10 | Interrupt ID for EOI or deactivate |
| gst_eoimode_i | input | 1 | Guest EOI mode: 1 splits priority drop from deactivation |
| ack_id_o | output | 10 | ID an acknowledge returns |
| phys_deact_o | output | 1 | Physical deactivation strobe |
| phys_id_o | output | 10 | Physical ID carried with the strobe |

## Verification
The bench builds the block with its default of four entries. That size is enough for a full priority contest across every slot, with ties and with the winner placed at each end of the bank. It also allows the underflow condition to be crossed in both directions, from two pending entries down to one. The five-bit count is driven from zero through matched and unmatched deactivations, and it is reloaded through the control word.

// File: rtl/virq_pkg.sv
package virq_pkg;
  localparam int LR_W   = 32;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 5;
  localparam int CNT_W  = 5;
  localparam int HW_BIT = 31;
  localparam int ST_LO  = 28;
  localparam int PRIO_LO = 23;
  localparam int PID_LO = 10;
  localparam int VID_LO = 0;
  localparam int CNT_LO = 27;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef enum logic [1:0] {
    ST_INV  = 2'b00,
    ST_PEND = 2'b01,
    ST_ACT  = 2'b10,
    ST_PA   = 2'b11
  } lr_state_e;

  typedef enum logic [1:0] {
    GOP_NONE = 2'd0,
    GOP_ACK  = 2'd1,
    GOP_EOI  = 2'd2,
    GOP_DIR  = 2'd3
  } gop_e;
endpackage

// File: rtl/virq_lr_entry.sv
module virq_lr_entry
  import virq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hv_we_i,
  input  logic [LR_W-1:0] hv_wdata_i,
  input  logic            ack_i,
  input  logic            deact_i,
  output logic [LR_W-1:0] lr_o
);
  logic [LR_W-1:0] lr_q, lr_d;
  logic [1:0]      st;

  assign st = lr_q[ST_LO+:2];

  always_comb begin
    lr_d = lr_q;
    if (hv_we_i)                          lr_d = hv_wdata_i;
    else if (ack_i && st == ST_PEND)      lr_d[ST_LO+:2] = ST_ACT;
    else if (deact_i && st[1])            lr_d[ST_LO+:2] = {1'b0, st[0]}; // 10->00, 11->01
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lr_q <= '0;
    else         lr_q <= lr_d;
  end

  assign lr_o = lr_q;
endmodule

// File: rtl/virq_prio_sel.sv
module virq_prio_sel
  import virq_pkg::*;
#(
  parameter int NUM_LR = 4,
  localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic [NUM_LR-1:0]             pend_i,
  input  logic [NUM_LR-1:0][PRIO_W-1:0] prio_i,
  output logic                          found_o,
  output logic [IDX_W-1:0]              idx_o
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '1;
    for (int i = 0; i < NUM_LR; i++) begin
      // strict compare keeps the lowest index on ties
      if (pend_i[i] && (!found_o || prio_i[i] < best)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        best    = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/virq_maint.sv
module virq_maint
  import virq_pkg::*;
#(
  parameter int NUM_LR = 4,
  localparam int PC_W = $clog2(NUM_LR + 1)
) (
  input  logic             en_i,
  input  logic             uie_i,
  input  logic             npie_i,
  input  logic [CNT_W-1:0] eoi_cnt_i,
  input  logic [PC_W-1:0]  pend_cnt_i,
  output logic [1:0]       misr_o,
  output logic             irq_o
);
  assign misr_o[0] = npie_i && (eoi_cnt_i != '0);
  assign misr_o[1] = uie_i && (pend_cnt_i <= PC_W'(1));
  assign irq_o     = en_i && (|misr_o);
endmodule

// File: rtl/virq_lr_ctrl.sv
module virq_lr_ctrl
  import virq_pkg::*;
#(
  parameter int NUM_LR = 4,
  localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hv_lr_we_i,
  input  logic [IDX_W-1:0] hv_lr_idx_i,
  input  logic             hv_ctrl_we_i,
  input  logic [31:0]      hv_wdata_i,
  input  logic [IDX_W-1:0] hv_rd_idx_i,
  output logic [31:0]      hv_lr_rdata_o,
  output logic [31:0]      hv_ctrl_o,
  output logic [1:0]       misr_o,
  output logic             maint_irq_o,
  input  logic [1:0]       gst_op_i,
  input  logic [9:0]       gst_id_i,
  input  logic             gst_eoimode_i,
  output logic [9:0]       ack_id_o,
  output logic             phys_deact_o,
  output logic [9:0]       phys_id_o
);
  localparam int PC_W = $clog2(NUM_LR + 1);
  localparam int PAD_W = LR_W - CNT_W - 3;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_LR-1:0][LR_W-1:0]   lr_w;
  logic [NUM_LR-1:0]             pend_v, match_v, ack_v, deact_v, we_v;
  logic [NUM_LR-1:0][PRIO_W-1:0] prio_v;
  logic                          en_q, uie_q, npie_q;
  logic [CNT_W-1:0]              cnt_q;
  logic                          sel_found;
  logic [IDX_W-1:0]              sel_idx;
  logic                          deact_req, ack_req, tgt_hit, any_match, hv_on_tgt;
  logic [IDX_W-1:0]              tgt_idx;
  logic [PC_W-1:0]               pend_cnt;
  logic                          phys_q;
  logic [ID_W-1:0]               pid_q;
  gop_e                          op;

  assign op        = gop_e'(gst_op_i);
  assign deact_req = (op == GOP_DIR) || (op == GOP_EOI && !gst_eoimode_i);
  assign ack_req   = (op == GOP_ACK) && en_q && sel_found;

  // per-entry decode, deactivation target search, pending population
  always_comb begin
    tgt_hit  = 1'b0;
    tgt_idx  = '0;
    pend_cnt = '0;
    for (int i = 0; i < NUM_LR; i++) begin
      pend_v[i]  = lr_w[i][ST_LO+:2] == ST_PEND;
      prio_v[i]  = lr_w[i][PRIO_LO+:PRIO_W];
      match_v[i] = (lr_w[i][ST_LO+:2] != ST_INV) && (lr_w[i][VID_LO+:ID_W] == gst_id_i);
      if (!tgt_hit && match_v[i] && lr_w[i][ST_LO+1]) begin
        tgt_hit = 1'b1;
        tgt_idx = IDX_W'(i);
      end
      pend_cnt = pend_cnt + PC_W'(lr_w[i][ST_LO]);
    end
  end

  assign any_match = |match_v;
  assign hv_on_tgt = hv_lr_we_i && (hv_lr_idx_i == tgt_idx);

  virq_prio_sel #(.NUM_LR(NUM_LR)) u_sel (
    .pend_i (pend_v),
    .prio_i (prio_v),
    .found_o(sel_found),
    .idx_o  (sel_idx)
  );

  for (genvar g = 0; g < NUM_LR; g++) begin : g_lr
    assign we_v[g]    = hv_lr_we_i && (hv_lr_idx_i == IDX_W'(g));
    assign ack_v[g]   = ack_req && (sel_idx == IDX_W'(g));
    assign deact_v[g] = deact_req && tgt_hit && (tgt_idx == IDX_W'(g));

    virq_lr_entry u_entry (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hv_we_i   (we_v[g]),
      .hv_wdata_i(hv_wdata_i),
      .ack_i     (ack_v[g]),
      .deact_i   (deact_v[g]),
      .lr_o      (lr_w[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      uie_q  <= 1'b0;
      npie_q <= 1'b0;
      cnt_q  <= '0;
    end else if (hv_ctrl_we_i) begin
      en_q   <= hv_wdata_i[0];
      uie_q  <= hv_wdata_i[1];
      npie_q <= hv_wdata_i[2];
      cnt_q  <= hv_wdata_i[CNT_LO+:CNT_W];
    end else if (deact_req && !any_match && cnt_q != CNT_MAX) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phys_q <= 1'b0;
      pid_q  <= '0;
    end else begin
      phys_q <= deact_req && tgt_hit && lr_w[tgt_idx][HW_BIT] && !hv_on_tgt;
      if (deact_req && tgt_hit) pid_q <= lr_w[tgt_idx][PID_LO+:ID_W];
    end
  end

  virq_maint #(.NUM_LR(NUM_LR)) u_maint (
    .en_i      (en_q),
    .uie_i     (uie_q),
    .npie_i    (npie_q),
    .eoi_cnt_i (cnt_q),
    .pend_cnt_i(pend_cnt),
    .misr_o    (misr_o),
    .irq_o     (maint_irq_o)
  );

  assign ack_id_o      = (en_q && sel_found) ? lr_w[sel_idx][VID_LO+:ID_W] : SPURIOUS_ID;
  assign hv_lr_rdata_o = lr_w[hv_rd_idx_i];
  assign hv_ctrl_o     = {cnt_q, {PAD_W{1'b0}}, npie_q, uie_q, en_q};
  assign phys_deact_o  = phys_q;
  assign phys_id_o     = pid_q;
endmodule

// File: rtl/virq_lr_ctrl_chk.sv
module virq_lr_ctrl_chk
  import virq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_we_i,
  input logic             ctrl_en_i,
  input logic             ctrl_uie_i,
  input logic             ctrl_npie_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [1:0]       misr_i,
  input logic             irq_i,
  input logic [1:0]       op_i,
  input logic             eoimode_i,
  input logic [ID_W-1:0]  ack_id_i,
  input logic             phys_i
);
  // strobe only follows a deactivating guest operation
  assert_strobe_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_i |-> $past(op_i == GOP_DIR || (op_i == GOP_EOI && !eoimode_i)));

  // EOI in split mode never strobes
  assert_split_eoi_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_i |-> !$past(op_i == GOP_EOI && eoimode_i));

  // count moves by one at most, and only on a deactivation or a control write
  assert_cnt_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != $past(cnt_i)) |-> ($past(ctrl_we_i) ||
      ($past(op_i == GOP_DIR || (op_i == GOP_EOI && !eoimode_i)) && cnt_i == $past(cnt_i) + 1'b1)));

  assert_misr_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_uie_i && !ctrl_npie_i) |-> misr_i == 2'b00);

  assert_irq_needs_en_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> ctrl_en_i);

  assert_spurious_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_en_i |-> ack_id_i == SPURIOUS_ID);
endmodule

bind virq_lr_ctrl virq_lr_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ctrl_we_i  (hv_ctrl_we_i),
  .ctrl_en_i  (hv_ctrl_o[0]),
  .ctrl_uie_i (hv_ctrl_o[1]),
  .ctrl_npie_i(hv_ctrl_o[2]),
  .cnt_i      (hv_ctrl_o[31:27]),
  .misr_i     (misr_o),
  .irq_i      (maint_irq_o),
  .op_i       (gst_op_i),
  .eoimode_i  (gst_eoimode_i),
  .ack_id_i   (ack_id_o),
  .phys_i     (phys_deact_o)
);

// File: tb/virq_lr_ctrl_test.sv
module virq_lr_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_LR = 4;

  // {expected index, prio3, prio2, prio1, prio0}
  localparam logic [21:0] ACK_VEC [4] = '{
    {2'd1, 5'd20, 5'd7,  5'd3,  5'd10},
    {2'd0, 5'd5,  5'd5,  5'd5,  5'd5},
    {2'd2, 5'd2,  5'd2,  5'd30, 5'd31},
    {2'd3, 5'd0,  5'd7,  5'd8,  5'd9}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hv_lr_we_i = 1'b0;
  logic [1:0]  hv_lr_idx_i = '0;
  logic        hv_ctrl_we_i = 1'b0;
  logic [31:0] hv_wdata_i = '0;
  logic [1:0]  hv_rd_idx_i = '0;
  logic [31:0] hv_lr_rdata_o, hv_ctrl_o;
  logic [1:0]  misr_o;
  logic        maint_irq_o;
  logic [1:0]  gst_op_i = '0;
  logic [9:0]  gst_id_i = '0;
  logic        gst_eoimode_i = 1'b0;
  logic [9:0]  ack_id_o;
  logic        phys_deact_o;
  logic [9:0]  phys_id_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  virq_lr_ctrl #(.NUM_LR(NUM_LR)) uut (.*);

  function automatic logic [31:0] mk(input logic hw, input logic [1:0] st, input logic [4:0] pr,
                                     input logic [9:0] pid, input logic [9:0] vid);
    return {hw, 1'b0, st, pr, 3'b000, pid, vid};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic lr_wr(input int idx, input logic [31:0] d);
    @(negedge clk_i);
    hv_lr_we_i = 1'b1; hv_lr_idx_i = 2'(idx); hv_wdata_i = d;
    @(posedge clk_i); #1;
    hv_lr_we_i = 1'b0;
  endtask

  task automatic ctrl_wr(input logic [31:0] d);
    @(negedge clk_i);
    hv_ctrl_we_i = 1'b1; hv_wdata_i = d;
    @(posedge clk_i); #1;
    hv_ctrl_we_i = 1'b0;
  endtask

  task automatic gop(input logic [1:0] op, input logic [9:0] id, input logic eom);
    @(negedge clk_i);
    gst_op_i = op; gst_id_i = id; gst_eoimode_i = eom;
    @(posedge clk_i); #1;
    gst_op_i = 2'd0; gst_eoimode_i = 1'b0;
  endtask

  task automatic both(input int idx, input logic [31:0] d, input logic [1:0] op, input logic [9:0] id);
    @(negedge clk_i);
    hv_lr_we_i = 1'b1; hv_lr_idx_i = 2'(idx); hv_wdata_i = d;
    gst_op_i = op; gst_id_i = id; gst_eoimode_i = 1'b0;
    @(posedge clk_i); #1;
    hv_lr_we_i = 1'b0; gst_op_i = 2'd0;
  endtask

  task automatic idle();
    @(posedge clk_i); #1;
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    hv_rd_idx_i = 2'(idx); #1;
    v = hv_lr_rdata_o;
  endtask

  task automatic clr_all();
    for (int j = 0; j < NUM_LR; j++) lr_wr(j, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    for (int j = 0; j < NUM_LR; j++) begin rd(j, v); chk("R1 entry", v, 0); end
    chk("R1 ctrl", hv_ctrl_o, 0);
    chk("R1 ack", 32'(ack_id_o), 1023);
    chk("R1 misr", 32'(misr_o), 0);
    chk("R1 irq", 32'(maint_irq_o), 0);
    chk("R1 phys", 32'(phys_deact_o), 0);

    // R2/R3 priority table
    ctrl_wr(32'h1);
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < NUM_LR; j++)
        lr_wr(j, mk(1'b0, 2'b01, ACK_VEC[k][5*j+:5], 10'd0, 10'(100 + j)));
      #1;
      chk("R2 ack select", 32'(ack_id_o), 100 + 32'(ACK_VEC[k][21:20]));
      gop(2'd1, 10'd0, 1'b0);
      rd(int'(ACK_VEC[k][21:20]), v);
      chk("R3 acked state", 32'(v[29:28]), 32'b10);
      clr_all();
    end

    // R4 disabled acknowledge
    ctrl_wr(32'h0);
    lr_wr(0, mk(1'b0, 2'b01, 5'd1, 10'd0, 10'd55));
    #1;
    chk("R4 spurious", 32'(ack_id_o), 1023);
    gop(2'd1, 10'd0, 1'b0);
    rd(0, v);
    chk("R4 no state change", 32'(v[29:28]), 32'b01);
    clr_all();

    // R5 hardware-linked EOI
    ctrl_wr(32'h1);
    lr_wr(0, mk(1'b1, 2'b10, 5'd4, 10'd27, 10'd27));
    gop(2'd2, 10'd27, 1'b0);
    chk("R5 strobe", 32'(phys_deact_o), 1);
    chk("R5 phys id", 32'(phys_id_o), 27);
    rd(0, v);
    chk("R5 entry invalid", 32'(v[29:28]), 0);
    idle();
    chk("R5 strobe one cycle", 32'(phys_deact_o), 0);

    // R6 software entry EOI
    lr_wr(1, mk(1'b0, 2'b10, 5'd4, 10'd9, 10'd40));
    gop(2'd2, 10'd40, 1'b0);
    chk("R6 no strobe", 32'(phys_deact_o), 0);
    rd(1, v);
    chk("R6 entry invalid", 32'(v[29:28]), 0);

    // R7 unmatched count
    gop(2'd3, 10'd500, 1'b0);
    chk("R7 unmatched inc", 32'(hv_ctrl_o[31:27]), 1);
    lr_wr(2, mk(1'b0, 2'b10, 5'd4, 10'd0, 10'd41));
    gop(2'd3, 10'd41, 1'b0);
    chk("R7 matched no inc", 32'(hv_ctrl_o[31:27]), 1);
    ctrl_wr({5'd30, 27'h1});
    gop(2'd3, 10'd501, 1'b0);
    gop(2'd3, 10'd502, 1'b0);
    chk("R7 saturate", 32'(hv_ctrl_o[31:27]), 31);

    // R8 not-present maintenance
    ctrl_wr(32'h5);
    chk("R8 cnt zero misr", 32'(misr_o), 0);
    gop(2'd2, 10'd600, 1'b0);
    chk("R8 misr bit0", 32'(misr_o), 1);
    chk("R12 irq when enabled", 32'(maint_irq_o), 1);
    ctrl_wr({5'd1, 27'h1});
    chk("R8 disabled misr", 32'(misr_o), 0);
    chk("R12 irq off", 32'(maint_irq_o), 0);

    // R12 enable gates the interrupt
    ctrl_wr({5'd1, 27'h4});
    chk("R12 misr set", 32'(misr_o), 1);
    chk("R12 irq gated", 32'(maint_irq_o), 0);

    // R9 underflow
    clr_all();
    ctrl_wr(32'h3);
    chk("R9 empty underflow", 32'(misr_o), 2);
    lr_wr(0, mk(1'b0, 2'b01, 5'd3, 10'd0, 10'd70));
    lr_wr(1, mk(1'b0, 2'b01, 5'd5, 10'd0, 10'd71));
    #1;
    chk("R9 two pending", 32'(misr_o), 0);
    gop(2'd1, 10'd0, 1'b0);
    chk("R9 raised at ack", 32'(misr_o), 2);
    clr_all();

    // R10 split EOI mode
    ctrl_wr(32'h1);
    lr_wr(3, mk(1'b1, 2'b10, 5'd2, 10'd33, 10'd60));
    gop(2'd2, 10'd60, 1'b1);
    chk("R10 eoi no strobe", 32'(phys_deact_o), 0);
    rd(3, v);
    chk("R10 eoi keeps active", 32'(v[29:28]), 32'b10);
    gop(2'd3, 10'd60, 1'b1);
    chk("R10 dir strobe", 32'(phys_deact_o), 1);
    chk("R10 dir phys id", 32'(phys_id_o), 33);
    rd(3, v);
    chk("R10 dir invalid", 32'(v[29:28]), 0);

    // R11 hypervisor write wins
    lr_wr(2, mk(1'b1, 2'b10, 5'd2, 10'd44, 10'd80));
    both(2, mk(1'b0, 2'b01, 5'd6, 10'd0, 10'd81), 2'd3, 10'd80);
    rd(2, v);
    chk("R11 write wins", v, mk(1'b0, 2'b01, 5'd6, 10'd0, 10'd81));
    chk("R11 no strobe", 32'(phys_deact_o), 0);
    chk("R11 no count", 32'(hv_ctrl_o[31:27]), 0);

    // R13 pending-and-active
    lr_wr(1, mk(1'b0, 2'b11, 5'd2, 10'd0, 10'd90));
    gop(2'd3, 10'd90, 1'b0);
    rd(1, v);
    chk("R13 back to pending", 32'(v[29:28]), 32'b01);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule